// File: doc/BRIEF.md
# Trigger-Stepped Traffic Light Controller

This block is a three-colour signal controller. It keeps a 2-bit colour state in a register. At each rising clock edge where the step input is high, the colour moves one place around the ring red, green, orange, and then back to red. When the step input is low, the colour stays as it is. The block does not make its own timing. Another circuit, such as a timer, an operator control or a traffic monitor, decides when the light changes and pulses the step input.

The main output is the look-ahead colour. This is the value the register will load at the next edge, computed from the present colour, the step input and the reset. A consumer therefore sees a change one cycle before the register takes it. The registered colour is also brought out, and a small decoder turns it into three one-hot lamp drives.

The colours are named RED (code 00), GREEN (code 01) and ORANGE (code 10). The transitions are STEP_RG, STEP_GO and STEP_OR when the step input is high, HOLD for any colour when it is low, and RECOVER, which takes the unused code 11 back to RED.

Top module: `tlc_stepper`

## Requirements
- R1: A synchronous, active-high reset loads RED (00) into the colour register at the clock edge where it is sampled high. The lamps then show red only.
- R2: The colour codes on both colour outputs are RED = 00, GREEN = 01 and ORANGE = 10.
- R3: If step is 0 at a clock edge and reset is low, the registered colour does not change (HOLD).
- R4: If step is 1 at a clock edge and reset is low, the colour advances RED→GREEN (STEP_RG), GREEN→ORANGE (STEP_GO) and ORANGE→RED (STEP_OR).
- R5: The look-ahead output equals, in the same cycle, the value the register will hold after the next edge. It follows the step input and the reset combinationally.
- R6: The code 11 is always followed by RED, whatever the step value (RECOVER).
- R7: The lamp bus is decoded from the registered colour, not from the look-ahead value. Bit 0 is red, bit 1 is green and bit 2 is orange, and exactly one bit is high for each legal code. Code 11 lights no lamp.
- R8: Reset takes priority over step. With both high, the look-ahead output shows RED and the register loads RED.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Advance request sampled at each edge |
| colour_next_o | output | 2 | Look-ahead colour (value loaded at the next edge) |
| colour_o | output | 2 | Registered colour |
| lamp_o | output | 3 | One-hot lamps: bit0 red, bit1 green, bit2 orange |

## Verification
The bench builds the block with its default parameters: a 2-bit colour code and a three-lamp decoder. With that build, every legal colour and every transition is reached from the top ports. The unused code 11 cannot be reached from reset, so the bench also instantiates the look-ahead logic and the lamp decoder on their own and drives code 11 into them directly. This brings RECOVER and the dark-lamp case within reach.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
    localparam int COLOUR_W = 2;
    localparam int LAMP_N   = 3;

    typedef enum logic [COLOUR_W-1:0] {
        C_RED    = 2'b00,
        C_GREEN  = 2'b01,
        C_ORANGE = 2'b10,
        C_BAD    = 2'b11
    } colour_t;
endpackage

// File: rtl/tlc_next_colour.sv
module tlc_next_colour
    import tlc_pkg::*;
(
    input  logic                clr,
    input  logic                step,
    input  logic [COLOUR_W-1:0] cur_i,
    output logic [COLOUR_W-1:0] nxt_o
);
    colour_t cur;
    colour_t nxt;

    assign cur = colour_t'(cur_i);

    always_comb begin
        nxt = C_RED;
        if (!clr) begin
            unique case (cur)
                C_RED:    nxt = step ? C_GREEN  : C_RED;
                C_GREEN:  nxt = step ? C_ORANGE : C_GREEN;
                C_ORANGE: nxt = step ? C_RED    : C_ORANGE;
                C_BAD:    nxt = C_RED;
            endcase
        end
    end

    assign nxt_o = nxt;

    // R6: RECOVER never produces anything but RED
    always_comb begin
        if (cur_i == 2'b11) begin
            p_recover_r6: assert (nxt_o == 2'b00 || $isunknown(cur_i));
        end
    end
endmodule

// File: rtl/tlc_colour_reg.sv
module tlc_colour_reg
    import tlc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                step,
    input  logic [COLOUR_W-1:0] d_i,
    output logic [COLOUR_W-1:0] q_o
);
    colour_t q;
    logic    rst_seen_q;

    always_ff @(posedge clk) begin
        if (rst) q <= C_RED;
        else     q <= colour_t'(d_i);
    end

    always_ff @(posedge clk) rst_seen_q <= rst;

    assign q_o = q;

    // R1: the edge after a sampled reset shows RED
    always @(negedge clk) begin
        if (rst_seen_q) p_reset_red_r1: assert (q == C_RED);
    end

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(q_o));

    p_step_rg_r4: assert property (@(posedge clk) disable iff (rst)
        (step && q_o == 2'b00) |=> (q_o == 2'b01));
    p_step_go_r4: assert property (@(posedge clk) disable iff (rst)
        (step && q_o == 2'b01) |=> (q_o == 2'b10));
    p_step_or_r4: assert property (@(posedge clk) disable iff (rst)
        (step && q_o == 2'b10) |=> (q_o == 2'b00));
endmodule

// File: rtl/tlc_lamp_dec.sv
module tlc_lamp_dec
    import tlc_pkg::*;
#(
    parameter int N_LAMP = LAMP_N
) (
    input  logic [COLOUR_W-1:0] colour_i,
    output logic [N_LAMP-1:0]   lamp_o
);
    for (genvar i = 0; i < N_LAMP; i++) begin : g_lamp
        assign lamp_o[i] = (colour_i == COLOUR_W'(i));
    end

    // R7: never more than one lamp lit
    always_comb begin
        p_lamp_onehot0_r7: assert ($onehot0(lamp_o) || $isunknown(colour_i));
    end
endmodule

// File: rtl/tlc_stepper.sv
module tlc_stepper
    import tlc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                step,
    output logic [COLOUR_W-1:0] colour_next_o,
    output logic [COLOUR_W-1:0] colour_o,
    output logic [LAMP_N-1:0]   lamp_o
);
    logic [COLOUR_W-1:0] nxt;
    logic [COLOUR_W-1:0] cur;

    tlc_next_colour u_next (
        .clr   (rst),
        .step  (step),
        .cur_i (cur),
        .nxt_o (nxt)
    );

    tlc_colour_reg u_reg (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .d_i  (nxt),
        .q_o  (cur)
    );

    tlc_lamp_dec #(.N_LAMP(LAMP_N)) u_lamp (
        .colour_i (cur),
        .lamp_o   (lamp_o)
    );

    assign colour_next_o = nxt;
    assign colour_o      = cur;

    // R5: the register always lands on the value announced one cycle earlier
    p_lookahead_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (colour_o == $past(colour_next_o)));

    // R7: a legal registered code lights exactly one lamp
    p_lamp_one_r7: assert property (@(posedge clk) disable iff (rst)
        (colour_o != 2'b11) |-> ($countones(lamp_o) == 1));

    // R8: reset overrides step on the look-ahead output
    always @(negedge clk) begin
        if (rst) p_rst_prio_r8: assert (colour_next_o == 2'b00);
    end
endmodule

// File: tb/tlc_stepper_tb.sv
module tlc_stepper_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step = 1'b0;
    logic [1:0] nxt_o, col_o;
    logic [2:0] lamp;

    int n_chk = 0;
    int n_fail = 0;
    logic [1:0] model = 2'b00;

    // isolated units for the unreachable code 11
    logic [1:0] u_cur = 2'b11;
    logic       u_step = 1'b0;
    logic [1:0] u_nxt;
    logic [2:0] u_lamp;

    always #10 clk = ~clk;   // 50 MHz

    tlc_stepper u_dut (
        .clk(clk), .rst(rst), .step(step),
        .colour_next_o(nxt_o), .colour_o(col_o), .lamp_o(lamp)
    );

    tlc_next_colour u_ns_unit (.clr(1'b0), .step(u_step), .cur_i(u_cur), .nxt_o(u_nxt));
    tlc_lamp_dec    u_ld_unit (.colour_i(u_cur), .lamp_o(u_lamp));

    // {step, colour before edge, expected look-ahead}
    localparam logic [4:0] VEC [16] = '{
        5'b1_00_01, 5'b0_01_01, 5'b1_01_10, 5'b1_10_00,
        5'b0_00_00, 5'b0_00_00, 5'b1_00_01, 5'b1_01_10,
        5'b0_10_10, 5'b1_10_00, 5'b1_00_01, 5'b1_01_10,
        5'b1_10_00, 5'b0_00_00, 5'b1_00_01, 5'b0_01_01
    };

    function automatic logic [1:0] ref_next(logic [1:0] s, logic t, logic r);
        if (r || s == 2'b11) return 2'b00;
        if (!t) return s;
        return (s == 2'b10) ? 2'b00 : s + 2'b01;
    endfunction

    task automatic chk2(string req, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #5;
        chk2("R1 reset colour", {2'b0, col_o}, 4'b0000);
        chk2("R1 reset lamps", {1'b0, lamp}, 4'b0001);
        @(negedge clk) rst = 1'b0;

        // table walk: R2 R3 R4 R5 R7
        for (int i = 0; i < 16; i++) begin
            step = VEC[i][4];
            #5;
            chk2("R2 colour code", {2'b0, col_o}, {2'b0, VEC[i][3:2]});
            chk2("R5 look-ahead", {2'b0, nxt_o}, {2'b0, VEC[i][1:0]});
            chk2("R7 lamp decode", {1'b0, lamp}, {1'b0, 3'b001 << VEC[i][3:2]});
            @(negedge clk);
            if (VEC[i][4]) chk2("R4 advance", {2'b0, col_o}, {2'b0, VEC[i][1:0]});
            else           chk2("R3 hold", {2'b0, col_o}, {2'b0, VEC[i][3:2]});
        end

        // random run against the reference model
        model = col_o;
        for (int i = 0; i < 300; i++) begin
            step = 1'($urandom_range(0, 1));
            #5;
            chk2("R5 random look-ahead", {2'b0, nxt_o}, {2'b0, ref_next(model, step, 1'b0)});
            chk2("R7 random lamp", {1'b0, lamp}, {1'b0, 3'b001 << model});
            model = ref_next(model, step, 1'b0);
            @(negedge clk);
            chk2("R4 R3 random colour", {2'b0, col_o}, {2'b0, model});
        end

        // drive to GREEN, then reset with step high: R8
        while (col_o != 2'b01) begin
            step = 1'b1;
            @(negedge clk);
        end
        step = 1'b1;
        rst  = 1'b1;
        #5;
        chk2("R8 look-ahead under reset", {2'b0, nxt_o}, 4'b0000);
        @(negedge clk);
        chk2("R8 reset beats step", {2'b0, col_o}, 4'b0000);
        chk2("R1 lamps after reset", {1'b0, lamp}, 4'b0001);
        rst  = 1'b0;
        step = 1'b0;
        #5;
        chk2("R3 hold after reset", {2'b0, nxt_o}, 4'b0000);

        // code 11 on the isolated units: R6 R7
        u_cur = 2'b11;
        u_step = 1'b0;
        #1;
        chk2("R6 recover step=0", {2'b0, u_nxt}, 4'b0000);
        u_step = 1'b1;
        #1;
        chk2("R6 recover step=1", {2'b0, u_nxt}, 4'b0000);
        chk2("R7 dark lamps on 11", {1'b0, u_lamp}, 4'b0000);
        u_cur = 2'b10;
        #1;
        chk2("R4 unit ORANGE->RED", {2'b0, u_nxt}, 4'b0000);
        chk2("R7 unit orange lamp", {1'b0, u_lamp}, 4'b0100);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule